// File: doc/BRIEF.md
# Transmit Diversity Symbol Precoder

This block accepts a serial stream of complex symbols, each a signed fixed-point I/Q pair with a valid strobe. It spreads the symbols over one, two or four antenna outputs using space-frequency block coding. A static mode input selects the antenna count. Each accepted symbol is first steered to one layer slot. Once a group of one, two or four symbols is complete, it is emitted as a block. The block uses plain, conjugated and negated copies of the group members, one column per clock cycle, with a per-antenna valid flag.

The single-antenna mode is a one-cycle registered pass-through. In the two- and four-antenna modes, the symbols of a group may arrive with idle cycles between them. A partly filled group waits until its last member arrives. Because the input delivers at most one symbol per cycle, the columns of one group are always finished before the next group can complete. For that reason no output buffering is needed.

Top module: `txdiv_precoder`

## Requirements
- R1: `ant_sel` encodes the antenna count as follows. 2'b00 selects one antenna, 2'b01 selects two, and both 2'b10 and 2'b11 select four.
- R2: With one antenna, every accepted symbol appears unchanged on port 0 one cycle after the clock edge that accepted it. Ports 1 to 3 stay invalid.
- R3: Each accepted symbol raises exactly one internal layer strobe. The strobe is that of its position within the group (0 to group size minus 1). No strobe is raised without an accepted symbol.
- R4: With two antennas, a group (X0, X1) produces two consecutive columns. The first column appears the cycle after X1 is accepted. Port 0 carries X0 and then X1. Port 1 carries -conj(X1) and then conj(X0). Ports 2 and 3 stay invalid.
- R5: With four antennas, a group (X0..X3) produces four consecutive columns on all four ports, starting the cycle after X3 is accepted. Port 0 carries X0, X1, 0, 0. Port 1 carries 0, 0, X2, X3. Port 2 carries -conj(X1), conj(X0), 0, 0. Port 3 carries 0, 0, -conj(X3), conj(X2).
- R6: Every negation saturates. The most negative code becomes the most positive code, and no negated value wraps.
- R7: A partial group produces no output, however many idle cycles separate its members. The group is emitted only when its last member is accepted.
- R8: A synchronous active-high reset discards any partial group, clears the grouping position, and drops all output valids the next cycle.
- R9: An output port whose valid flag is low drives zero on both I and Q.
- R10: While a group is being emitted, the output valid mask is 4'b0001, 4'b0011 or 4'b1111 for one, two or four antennas respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ant_sel | input | 2 | Antenna-count select, held static between resets |
| sym_valid | input | 1 | Input symbol strobe |
| sym_re | input | 16 | Input in-phase part, signed |
| sym_im | input | 16 | Input quadrature part, signed |
| ant_valid | output | 4 | Per-antenna output valid |
| ant_re | output | 64 | Per-antenna in-phase outputs, port p at bits [16p+15:16p] |
| ant_im | output | 64 | Per-antenna quadrature outputs, same packing |

## Verification
Several properties are checked on every cycle by the assertions. These are the one-hot layer strobe, the output valid mask for each mode, zero data on idle ports, the one-cycle pass-through, the two-cycle valid burst in two-antenna mode, and quiet outputs after reset. Other behaviour is shown only by the bench scenarios. This covers the exact column contents in both diversity modes, saturation of the most negative code, a group held open across idle gaps, and a reset that lands in the middle of a group.

// File: rtl/txdiv_pkg.sv
package txdiv_pkg;

    localparam int IQ_W      = 16;
    localparam int MAX_PORTS = 4;
    localparam int PH_W      = $clog2(MAX_PORTS);

    localparam logic signed [IQ_W-1:0] IQ_MIN = {1'b1, {(IQ_W-1){1'b0}}};
    localparam logic signed [IQ_W-1:0] IQ_MAX = ~IQ_MIN;

    typedef enum logic [1:0] {
        ANT_ONE  = 2'b00,
        ANT_TWO  = 2'b01,
        ANT_FOUR = 2'b10,
        ANT_FOURB = 2'b11
    } ant_mode_e;

    typedef struct packed {
        logic signed [IQ_W-1:0] re;
        logic signed [IQ_W-1:0] im;
    } cplx_t;

    typedef cplx_t [MAX_PORTS-1:0] grp_t;

    // saturating two's complement negate
    function automatic logic signed [IQ_W-1:0] sat_neg(input logic signed [IQ_W-1:0] v);
        return (v == IQ_MIN) ? IQ_MAX : -v;
    endfunction

    function automatic cplx_t conj_c(input cplx_t x);
        cplx_t r;
        r.re = x.re;
        r.im = sat_neg(x.im);
        return r;
    endfunction

    function automatic cplx_t neg_conj_c(input cplx_t x);
        cplx_t r;
        r.re = sat_neg(x.re);
        r.im = x.im;
        return r;
    endfunction

    // index of the final slot of a group
    function automatic logic [PH_W-1:0] last_slot(input ant_mode_e m);
        case (m)
            ANT_ONE: return PH_W'(0);
            ANT_TWO: return PH_W'(1);
            default: return PH_W'(MAX_PORTS-1);
        endcase
    endfunction

    function automatic logic [MAX_PORTS-1:0] last_slot_hot(input ant_mode_e m);
        return MAX_PORTS'(1) << last_slot(m);
    endfunction

    function automatic logic [MAX_PORTS-1:0] port_mask(input ant_mode_e m);
        case (m)
            ANT_ONE: return MAX_PORTS'(4'b0001);
            ANT_TWO: return MAX_PORTS'(4'b0011);
            default: return MAX_PORTS'(4'b1111);
        endcase
    endfunction

    // symbol placed on antenna port in column col
    function automatic cplx_t sfbc_pick(input ant_mode_e m, input logic [1:0] port,
                                        input logic [1:0] col, input grp_t g);
        cplx_t z;
        z = '0;
        case (m)
            ANT_ONE: begin
                if (port == 2'd0 && col == 2'd0) z = g[0];
            end
            ANT_TWO: begin
                if (port == 2'd0)      z = g[col[0]];
                else if (port == 2'd1) z = col[0] ? conj_c(g[0]) : neg_conj_c(g[1]);
            end
            default: begin
                // column pair col[1] belongs to ports whose low bit matches
                if (port[0] == col[1]) begin
                    if (!port[1])   z = g[{col[1], col[0]}];
                    else if (col[0]) z = conj_c(g[{col[1], 1'b0}]);
                    else            z = neg_conj_c(g[{col[1], 1'b1}]);
                end
            end
        endcase
        return z;
    endfunction

endpackage

// File: rtl/txdiv_layer_demux.sv
module txdiv_layer_demux
    import txdiv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  ant_mode_e            mode,
    input  logic                 in_valid,
    input  cplx_t                in_sym,
    output logic [MAX_PORTS-1:0] layer_vld,
    output grp_t                 grp_full
);

    logic [PH_W-1:0] slot_q;
    grp_t            hold_q;
    logic            closing;

    always_comb begin
        layer_vld = '0;
        if (in_valid) layer_vld[slot_q] = 1'b1;
    end

    assign closing = |(layer_vld & last_slot_hot(mode));

    // completed group as seen by the emitter: held slots plus the live symbol
    always_comb begin
        grp_full         = hold_q;
        grp_full[slot_q] = in_sym;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (in_valid) begin
            slot_q <= closing ? '0 : slot_q + 1'b1;
        end
    end

    for (genvar l = 0; l < MAX_PORTS; l++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q[l] <= '0;
            end else if (layer_vld[l]) begin
                hold_q[l] <= in_sym;
            end
        end
    end

endmodule

// File: rtl/txdiv_sfbc_emitter.sv
module txdiv_sfbc_emitter
    import txdiv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  ant_mode_e            mode,
    input  logic                 grp_load,
    input  grp_t                 grp_in,
    output logic [MAX_PORTS-1:0] out_valid,
    output grp_t                 out_sym
);

    grp_t            grp_q;
    logic [PH_W-1:0] col_q;
    logic            active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q    <= '0;
            col_q    <= '0;
            active_q <= 1'b0;
        end else if (grp_load) begin
            grp_q    <= grp_in;
            col_q    <= '0;
            active_q <= 1'b1;
        end else if (active_q) begin
            if (col_q == last_slot(mode)) begin
                active_q <= 1'b0;
                col_q    <= '0;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
        assign out_sym[p]   = active_q ? sfbc_pick(mode, 2'(p), 2'(col_q), grp_q) : '0;
        assign out_valid[p] = active_q & port_mask(mode)[p];
    end

endmodule

// File: rtl/txdiv_precoder.sv
module txdiv_precoder
    import txdiv_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [1:0]                    ant_sel,
    input  logic                          sym_valid,
    input  logic signed [IQ_W-1:0]        sym_re,
    input  logic signed [IQ_W-1:0]        sym_im,
    output logic [MAX_PORTS-1:0]          ant_valid,
    output logic [MAX_PORTS*IQ_W-1:0]     ant_re,
    output logic [MAX_PORTS*IQ_W-1:0]     ant_im
);

    ant_mode_e            mode;
    cplx_t                in_sym;
    logic [MAX_PORTS-1:0] layer_vld;
    logic                 grp_load;
    grp_t                 grp_full;
    grp_t                 out_sym;

    assign mode      = ant_mode_e'(ant_sel);
    assign in_sym.re = sym_re;
    assign in_sym.im = sym_im;
    assign grp_load  = |(layer_vld & last_slot_hot(mode));

    txdiv_layer_demux u_demux (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .in_valid  (sym_valid),
        .in_sym    (in_sym),
        .layer_vld (layer_vld),
        .grp_full  (grp_full)
    );

    txdiv_sfbc_emitter u_emit (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .grp_load  (grp_load),
        .grp_in    (grp_full),
        .out_valid (ant_valid),
        .out_sym   (out_sym)
    );

    for (genvar p = 0; p < MAX_PORTS; p++) begin : g_out
        assign ant_re[p*IQ_W +: IQ_W] = out_sym[p].re;
        assign ant_im[p*IQ_W +: IQ_W] = out_sym[p].im;
    end

endmodule

// File: rtl/txdiv_precoder_chk.sv
module txdiv_precoder_chk
    import txdiv_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic [1:0]                ant_sel,
    input logic                      sym_valid,
    input logic signed [IQ_W-1:0]    sym_re,
    input logic signed [IQ_W-1:0]    sym_im,
    input logic [MAX_PORTS-1:0]      layer_vld,
    input logic [MAX_PORTS-1:0]      ant_valid,
    input logic [MAX_PORTS*IQ_W-1:0] ant_re,
    input logic [MAX_PORTS*IQ_W-1:0] ant_im
);

    p_layer_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> $countones(layer_vld) == 1);

    p_layer_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |-> layer_vld == '0);

    p_passthru_r2: assert property (@(posedge clk) disable iff (rst)
        (ant_sel == 2'b00 && sym_valid) |=>
            (ant_valid == 4'b0001 && ant_re[IQ_W-1:0] == $past(sym_re)
             && ant_im[IQ_W-1:0] == $past(sym_im)));

    p_valid_mask_r10: assert property (@(posedge clk) disable iff (rst)
        ant_valid != '0 |-> ant_valid == port_mask(ant_mode_e'(ant_sel)));

    p_two_burst_r4: assert property (@(posedge clk) disable iff (rst)
        (ant_sel == 2'b01 && $rose(ant_valid[0])) |=> ant_valid[0]);

    p_after_reset_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ant_valid == '0);

    for (genvar p = 0; p < MAX_PORTS; p++) begin : g_idle
        p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
            !ant_valid[p] |-> (ant_re[p*IQ_W +: IQ_W] == '0 && ant_im[p*IQ_W +: IQ_W] == '0));
    end

endmodule

bind txdiv_precoder txdiv_precoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ant_sel   (ant_sel),
    .sym_valid (sym_valid),
    .sym_re    (sym_re),
    .sym_im    (sym_im),
    .layer_vld (layer_vld),
    .ant_valid (ant_valid),
    .ant_re    (ant_re),
    .ant_im    (ant_im)
);

// File: tb/txdiv_precoder_test.sv
module txdiv_precoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  ant_sel = 2'b00;
    logic        sym_valid = 1'b0;
    logic signed [15:0] sym_re = '0;
    logic signed [15:0] sym_im = '0;
    logic [3:0]  ant_valid;
    logic [63:0] ant_re;
    logic [63:0] ant_im;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int xr [4];
    int xi [4];

    // vector: [129:128] antenna select, symbol k at [32k+31:32k] = {re, im}
    localparam logic [129:0] VECS [6] = '{
        {2'd0, 96'h0, 32'h1234_FEDC},
        {2'd1, 64'h0, 32'h0300_FC00, 32'h0100_0200},
        {2'd1, 64'h0, 32'h8000_0005, 32'h7FFF_8000},
        {2'd2, 32'h0040_0041, 32'h0030_FFCF, 32'h0020_0021, 32'h0010_FFF0},
        {2'd2, 32'h8000_7FFF, 32'h0001_8000, 32'h8000_8000, 32'h7FFF_8000},
        {2'd3, 32'h1111_2222, 32'hEEEE_DDDD, 32'h3333_4444, 32'hCCCC_BBBB}
    };
    string tags [6] = '{"R2", "R4", "R6", "R5", "R6", "R1"};

    txdiv_precoder uut (
        .clk (clk), .rst (rst), .ant_sel (ant_sel),
        .sym_valid (sym_valid), .sym_re (sym_re), .sym_im (sym_im),
        .ant_valid (ant_valid), .ant_re (ant_re), .ant_im (ant_im)
    );

    always #5 clk = ~clk;

    function automatic int sneg(input int v);
        return (v <= -32768) ? 32767 : -v;
    endfunction

    function automatic int gsize(input int m);
        return (m == 0) ? 1 : (m == 1) ? 2 : 4;
    endfunction

    // expected sample for port p, column c, from the mapping rules
    task automatic expect_at(input int m, input int p, input int c,
                             output int er, output int ei, output bit ev);
        int pair, k, b;
        er = 0; ei = 0;
        ev = (p < gsize(m));
        if (!ev) return;
        if (m == 0) begin
            er = xr[0]; ei = xi[0];
        end else if (m == 1) begin
            if (p == 0) begin er = xr[c]; ei = xi[c]; end
            else if (c == 0) begin er = sneg(xr[1]); ei = xi[1]; end
            else begin er = xr[0]; ei = sneg(xi[0]); end
        end else begin
            pair = c / 2; k = c % 2; b = 2 * pair;
            if ((p % 2) != pair) return;
            if (p < 2) begin er = xr[b+k]; ei = xi[b+k]; end
            else if (k == 0) begin er = sneg(xr[b+1]); ei = xi[b+1]; end
            else begin er = xr[b]; ei = sneg(xi[b]); end
        end
    endtask

    task automatic check_port(input string req, input int p, input bit ev, input int er, input int ei);
        int ar, ai;
        ar = int'($signed(ant_re[p*16 +: 16]));
        ai = int'($signed(ant_im[p*16 +: 16]));
        checks++;
        if (ant_valid[p] !== ev || ar != er || ai != ei) begin
            failures++;
            $display("FAIL %s port%0d actual v=%0b re=%0d im=%0d expected v=%0b re=%0d im=%0d",
                     req, p, ant_valid[p], ar, ai, ev, er, ei);
        end
    endtask

    task automatic check_col(input string req, input int m, input int c);
        int er, ei;
        bit ev;
        for (int p = 0; p < 4; p++) begin
            expect_at(m, p, c, er, ei, ev);
            check_port(req, p, ev, er, ei);
        end
    endtask

    task automatic check_idle(input string req);
        for (int p = 0; p < 4; p++) check_port(req, p, 1'b0, 0, 0);
    endtask

    task automatic drive_sym(input int k);
        @(negedge clk);
        sym_valid = 1'b1;
        sym_re = 16'(xr[k]);
        sym_im = 16'(xi[k]);
    endtask

    // columns appear from the cycle after the last symbol's accepting edge
    task automatic emit_and_check(input string req, input int m);
        @(negedge clk);
        sym_valid = 1'b0;
        check_col(req, m, 0);
        for (int c = 1; c < gsize(m); c++) begin
            @(negedge clk);
            check_col(req, m, c);
        end
        @(negedge clk);
        check_idle("R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog R7 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R8");
        rst = 1'b0;

        // table-driven groups in every mode
        for (int v = 0; v < 6; v++) begin
            int m;
            m = int'(VECS[v][129:128]);
            for (int k = 0; k < 4; k++) begin
                xr[k] = int'($signed(VECS[v][k*32+16 +: 16]));
                xi[k] = int'($signed(VECS[v][k*32 +: 16]));
            end
            @(negedge clk);
            ant_sel = 2'(m);
            for (int k = 0; k < gsize(m); k++) drive_sym(k);
            emit_and_check(tags[v], m);
        end

        // R7: four-antenna group with idle gaps between members
        xr = '{100, -200, 300, -32768};
        xi = '{-5, 6, -32768, 8};
        @(negedge clk);
        ant_sel = 2'b10;
        for (int k = 0; k < 3; k++) begin
            drive_sym(k);
            for (int g = 0; g < 2; g++) begin
                @(negedge clk);
                sym_valid = 1'b0;
                check_idle("R7");
            end
        end
        drive_sym(3);
        emit_and_check("R7", 2);

        // R8: reset in the middle of a two-antenna group discards the partial group
        @(negedge clk);
        ant_sel = 2'b01;
        xr[0] = 7; xi[0] = 7;
        drive_sym(0);
        @(negedge clk);
        sym_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check_idle("R8");
        rst = 1'b0;
        xr[0] = -1000; xi[0] = 2000;
        xr[1] = 3000;  xi[1] = -32768;
        drive_sym(0);
        drive_sym(1);
        emit_and_check("R8", 1);

        // R2: back-to-back single-antenna symbols
        @(negedge clk);
        ant_sel = 2'b00;
        xr[0] = -32768; xi[0] = 32767;
        drive_sym(0);
        @(negedge clk);
        check_col("R2", 0, 0);
        xr[0] = 55; xi[0] = -66;
        sym_re = 16'(xr[0]); sym_im = 16'(xi[0]);
        @(negedge clk);
        sym_valid = 1'b0;
        check_col("R2", 0, 0);
        @(negedge clk);
        check_idle("R9");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule